// File: doc/BRIEF.md
# Serial Register-Access Master for a Radio Baseband

This block lets on-chip logic read and write the internal registers of an external radio baseband device over a four-wire serial control port. That port has a serial clock, an active-low select, a read/not-write line and an address/data strobe, plus one bidirectional data wire. The host side presents an address, a direction and (for writes) a data byte with a one-cycle request. The block runs one framed transfer and ends it with a one-cycle completion pulse, which carries the returned byte on reads.

The serial clock is made by dividing the system clock by a programmable even value. The strobe is high while the address is on the data wire and low while data is on it. Every outgoing line changes only at the falling serial edge, and the baseband samples on the rising edge. On a read the block stops driving the data wire after the address phase, through an output-enable meant for the pad. It then captures the returned byte on the following rising edges.

Top module: `sctl_master`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, sd_oe is 0, done is 0 and busy is 0.
- R2: With H = floor(div_cfg/2), sclk stays high for H system clocks and low for H system clocks while a frame runs.
- R3: A div_cfg of 0 or 1 selects the default divider of 14 (H = 7). An odd div_cfg behaves as the next lower even value.
- R4: cs_n falls one clock after the request is accepted. sclk is 0 at that point and first rises H clocks later.
- R5: A frame has exactly 15 rising sclk edges. At the first 7, strobe is 1 and sd_out carries the 7-bit address MSB first. At the last 8, strobe is 0.
- R6: strobe, rnw and sd_out change only in the clock where sclk falls, for as long as cs_n is low.
- R7: rnw is 1 for a read and 0 for a write, and it holds that value for the whole frame.
- R8: On a read, sd_oe goes to 0 at the fall that ends the address phase. The 8 bits on sd_in at the following rising edges are returned MSB first on rd_data.
- R9: On a write, sd_oe stays 1 for the whole frame and sd_out carries the 8-bit write data MSB first at the last 8 rising edges.
- R10: cs_n returns to 1 at the sclk fall after the 15th rising edge, which is 30·H clocks after it fell. done is then high for exactly one clock, one clock later, with rd_data valid in that clock.
- R11: A request while busy is ignored. A change of div_cfg during a frame does not affect that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 8 | Serial clock divider, sampled when a request is accepted |
| req_valid | input | 1 | One-cycle transfer request, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Baseband register address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low select |
| rnw | output | 1 | Read/not-write line |
| strobe | output | 1 | 1 during the address phase, 0 during the data phase |
| sd_out | output | 1 | Outgoing serial data |
| sd_oe | output | 1 | Pad output enable for the data wire |
| sd_in | input | 1 | Incoming serial data from the pad |

## Verification
A wrong bit counter or phase register shows first as a misplaced rising edge, or as a strobe that flips one bit early or late. That appears within one serial period of the fault. A wrong half-period count moves every later edge, so the very first rising edge after select already misses its expected clock. A turnaround error shows as sd_oe still high at the first data rise of a read, and a capture or shift error shows as a wrong rd_data in the completion cycle.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } sctl_state_e;
endpackage

// File: rtl/sctl_halfdiv.sv
module sctl_halfdiv #(
    parameter int DIV_W       = 8,
    parameter int DEFAULT_DIV = 14,
    localparam int HALF_W     = DIV_W - 1
) (
    input  logic [DIV_W-1:0]  cfg,
    output logic [HALF_W-1:0] half
);
    logic [HALF_W-1:0] raw;

    always_comb begin
        raw  = cfg[DIV_W-1:1];
        half = (raw == '0) ? HALF_W'(DEFAULT_DIV / 2) : raw;
    end
endmodule

// File: rtl/sctl_timer.sv
module sctl_timer #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = (cnt_q == '0);
        if (load || tick) cnt_d = half - HALF_W'(1);
        else              cnt_d = cnt_q - HALF_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sctl_master.sv
module sctl_master
    import sctl_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int DEFAULT_DIV = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              cs_n,
    output logic              rnw,
    output logic              strobe,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              sd_in
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int HALF_W  = DIV_W - 1;

    typedef struct packed {
        sctl_state_e       st;
        logic              sclk;
        logic              cs_n;
        logic              strobe;
        logic              rnw;
        logic              oe;
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rdata;
        logic [BIT_W-1:0]  bitn;
        logic              done;
        logic [HALF_W-1:0] half;
    } regs_t;

    regs_t r_d, r_q;

    logic [HALF_W-1:0] cfg_half;
    logic [HALF_W-1:0] timer_half;
    logic              accept;
    logic              tick;

    sctl_halfdiv #(.DIV_W(DIV_W), .DEFAULT_DIV(DEFAULT_DIV)) u_halfdiv (
        .cfg  (div_cfg),
        .half (cfg_half)
    );

    assign accept     = (r_q.st == ST_IDLE) && req_valid;
    assign timer_half = (r_q.st == ST_IDLE) ? cfg_half : r_q.half;

    sctl_timer #(.HALF_W(HALF_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .half  (timer_half),
        .tick  (tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_SETUP;
                    r_d.cs_n   = 1'b0;
                    r_d.sclk   = 1'b0;
                    r_d.strobe = 1'b1;
                    r_d.rnw    = ~req_write;
                    r_d.oe     = 1'b1;
                    r_d.sh     = {req_addr, req_wdata};
                    r_d.bitn   = '0;
                    r_d.half   = cfg_half;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    r_d.st   = ST_RUN;
                    r_d.sclk = 1'b1;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        if (r_q.rnw && (r_q.bitn >= BIT_W'(ADDR_W)))
                            r_d.rx = {r_q.rx[DATA_W-2:0], sd_in};
                    end else if (r_q.bitn == BIT_W'(FRAME_W - 1)) begin
                        r_d.sclk = 1'b0;
                        r_d.cs_n = 1'b1;
                        r_d.oe   = 1'b0;
                        r_d.st   = ST_DONE;
                    end else begin
                        r_d.sclk = 1'b0;
                        r_d.bitn = r_q.bitn + BIT_W'(1);
                        r_d.sh   = {r_q.sh[FRAME_W-2:0], 1'b0};
                        if (r_q.bitn == BIT_W'(ADDR_W - 1)) begin
                            r_d.strobe = 1'b0;
                            r_d.oe     = ~r_q.rnw;
                        end
                    end
                end
            end
            ST_DONE: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                if (r_q.rnw) r_d.rdata = r_q.rx;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rdata;
    assign sclk    = r_q.sclk;
    assign cs_n    = r_q.cs_n;
    assign rnw     = r_q.rnw;
    assign strobe  = r_q.strobe;
    assign sd_out  = r_q.sh[FRAME_W-1];
    assign sd_oe   = r_q.oe;

    // Deselected port keeps the clock low and the wire released.
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && !sd_oe));

    assert_strobe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && (strobe != $past(strobe))) |-> $fell(sclk));

    assert_sdout_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && (sd_out != $past(sd_out))) |-> $fell(sclk));

    assert_rnw_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(rnw));

    assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rnw && !strobe) |-> !sd_oe);

    assert_done_after_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cs_n) && !$past(cs_n, 2)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_sctl_master.sv
module sim_sctl_master;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_cfg = 8'd0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [6:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, sclk, cs_n, rnw, strobe, sd_out, sd_oe;
    logic [7:0] rd_data;
    logic       sd_in = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sctl_master u0 (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .sclk(sclk), .cs_n(cs_n), .rnw(rnw), .strobe(strobe),
        .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [6:0] a, input logic [7:0] wd,
                        input logic [7:0] rv, input logic [7:0] cfg, input bit poke);
        int h;
        int rises = 0;
        int falls = 0;
        int dbit = 0;
        int cs_bad = 0;
        logic prev = 1'b0;
        h = (cfg < 2) ? 7 : int'(cfg >> 1);
        @(negedge clk);
        div_cfg = cfg; req_write = wr; req_addr = a; req_wdata = wd;
        req_valid = 1'b1; sd_in = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cs_n == 1'b0 && sclk == 1'b0, "R4", "select low, clock low after accept",
            int'({cs_n, sclk}), 0);
        for (int t = 0; t <= 30*h + 1; t++) begin
            if (t > 0) @(negedge clk);
            if (poke && t == 3) begin req_valid = 1'b1; div_cfg = 8'd2; end
            if (poke && t == 4) req_valid = 1'b0;
            if (sclk && !prev) begin
                bit eoe;
                chk(t == h + 2*h*rises, "R2", "rising edge time", t, h + 2*h*rises);
                chk(strobe == (rises < 7), "R5", "strobe at rise", int'(strobe), int'(rises < 7));
                eoe = (rises < 7) || wr;
                chk(sd_oe == eoe, wr ? "R9" : "R8", "sd_oe at rise", int'(sd_oe), int'(eoe));
                if (eoe) begin
                    logic eb;
                    eb = (rises < 7) ? a[6-rises] : wd[14-rises];
                    chk(sd_out == eb, (rises < 7) ? "R5" : "R9", "sd_out bit", int'(sd_out), int'(eb));
                end
                chk(rnw == !wr, "R7", "rnw level", int'(rnw), int'(!wr));
                rises++;
            end
            if (!sclk && prev) begin
                chk(t == 2*h*(falls+1), "R2", "falling edge time", t, 2*h*(falls+1));
                falls++;
                if (!wr && !strobe && !cs_n && dbit < 8) begin
                    sd_in = rv[7-dbit];
                    dbit++;
                end
            end
            prev = sclk;
            if (t < 30*h && cs_n) cs_bad++;
            if (t >= 30*h - 1) begin
                chk(cs_n == (t >= 30*h), "R10", "select release time", int'(cs_n), int'(t >= 30*h));
                chk(done == (t == 30*h + 1), "R10", "done timing", int'(done), int'(t == 30*h + 1));
            end else if (done) begin
                chk(1'b0, "R10", "early done", t, 30*h + 1);
            end
        end
        chk(cs_bad == 0, "R10", "select stayed low through frame", cs_bad, 0);
        chk(rises == 15, "R5", "rising edge count", rises, 15);
        if (!wr) chk(rd_data == rv, "R8", "read data", int'(rd_data), int'(rv));
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && sd_oe == 1'b0 && done == 1'b0 && busy == 1'b0,
            "R1", "reset state", int'({cs_n, sclk, sd_oe, done, busy}), 16);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0, "R1", "idle after reset", int'({cs_n, busy}), 2);

        // Divider sweep, both directions: even, odd (R3 rounds down), and default (R3).
        for (int c = 0; c <= 9; c++) begin
            logic [6:0] ad;
            logic [7:0] dv;
            ad = 7'(7'h55 ^ (c * 13));
            dv = 8'(8'hA3 + c * 37);
            xfer(1'b1, ad, dv, 8'h00, 8'(c), 1'b0);
            xfer(1'b0, ad, 8'h00, ~dv, 8'(c), 1'b0);
        end
        // Address and data corner patterns at the fastest divider.
        xfer(1'b1, 7'h7F, 8'hFF, 8'h00, 8'd2, 1'b0);
        xfer(1'b1, 7'h00, 8'h00, 8'h00, 8'd2, 1'b0);
        xfer(1'b0, 7'h40, 8'h00, 8'h80, 8'd2, 1'b0);
        xfer(1'b0, 7'h01, 8'h00, 8'h01, 8'd3, 1'b0);
        xfer(1'b0, 7'h2A, 8'h00, 8'h5A, 8'd14, 1'b0);

        // R11: request and divider change during a frame are ignored.
        xfer(1'b1, 7'h33, 8'hC6, 8'h00, 8'd14, 1'b1);
        begin
            int extra = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!cs_n || busy) extra++;
            end
            chk(extra == 0, "R11", "no second frame after busy request", extra, 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule